// File: doc/BRIEF.md
# Commutation Preload Control Register

This block keeps the per-channel output-control fields of a multi-channel PWM timer: an enable bit, a complementary-output enable bit and a three-bit output mode for every channel. The output stage reads the active copy of these fields. Software can have a write to them land directly in the active copy. It can also have the write land in a shadow copy, which moves into the active copy for all channels at once when a commutation event occurs.

A commutation event comes from a software strobe. A configuration bit can also allow a rising edge on a trigger input to cause one. A second configuration bit selects whether each channel's DMA request follows its own capture/compare event or the update event. The block only holds that selection and presents it. A lock level input protects the two bits that select how commutation works. When the lock level is above zero, those bits keep their value and software writes to them are dropped.

Top module: `ccp_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the active and shadow channel fields, `preload_on`, `src_trig`, `dma_on_update` and the trigger edge detector are all cleared to 0. The cleared values are visible after that edge.
- R2: A channel write uses `wr_en`=1 with `wr_sel`=1. Channel c occupies `wr_data` bits 5c..5c+4: bit 5c is the enable, bit 5c+1 is the complementary enable, and bits 5c+4..5c+2 are the mode. When `preload_on`=0, the written value appears on `ch_en`, `ch_nen` and `ch_mode` after the same clock edge.
- R3: When `preload_on`=1, a channel write changes only the shadow copy and the outputs keep their value. On a commutation event, the whole shadow is copied to the outputs in one cycle. When `preload_on`=0, a commutation event does not change the outputs.
- R4: When `src_trig`=0, only `sw_com`=1 causes a commutation event, and `trig_in` has no effect on the outputs.
- R5: When `src_trig`=1, a commutation event occurs on `sw_com` and also on a 0-to-1 transition of `trig_in` between two consecutive clock edges. Holding `trig_in` high causes only one event. A level that was already high when `src_trig` was set causes no event.
- R6: If a channel write and a commutation event fall in the same cycle while `preload_on`=1, the outputs take the shadow value from before that write. The newly written value stays pending in the shadow.
- R7: A configuration write uses `wr_en`=1 with `wr_sel`=0. `wr_data` bit 0 sets `preload_on` and bit 1 sets `src_trig`. When `lock_lvl` is nonzero, these two bits keep their values, no error is raised, and bit 2 is still written.
- R8: `wr_data` bit 2 of a configuration write appears on `dma_on_update` after that edge. A value of 1 selects update-event DMA requests and 0 selects per-channel capture/compare requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: configuration word, 1: channel fields word |
| wr_data | input | 5*NCH | Write data |
| lock_lvl | input | 2 | Protection level; nonzero freezes preload_on and src_trig |
| sw_com | input | 1 | Software commutation strobe |
| trig_in | input | 1 | Trigger input, rising edge may commit |
| ch_en | output | NCH | Active channel enables |
| ch_nen | output | NCH | Active complementary enables |
| ch_mode | output | 3*NCH | Active output modes, channel c at bits 3c+2..3c |
| preload_on | output | 1 | Shadowed update mode selected |
| src_trig | output | 1 | Trigger edges also commit |
| dma_on_update | output | 1 | DMA request source selection |

## Verification
The bench sweeps every configuration word under every lock level. A lock that failed to protect would change `preload_on` or `src_trig`, and a lock that covered too much would freeze `dma_on_update`. It drives the trigger through held-high and already-high levels, where a level-sensitive detector would commit repeatedly or commit at the moment `src_trig` is set. It also drives `trig_in` while `src_trig`=0, where a design that ignored the selection bit would commit. It issues a write together with a commutation in the same cycle, where a design that forwarded the write would show the new value at once instead of the old shadow. It also checks that a commutation with preload off has no effect.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
    localparam int SLOT_W = 5;
    localparam int MODE_W = 3;
    localparam int CFG_W  = 3;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              nen;
        logic              en;
    } chan_ctl_t;

    typedef struct packed {
        logic dma_upd;
        logic src_trig;
        logic preload;
    } cfg_t;

    function automatic logic is_locked(input logic [1:0] lvl);
        return lvl != 2'd0;
    endfunction
endpackage

// File: rtl/ccp_cfg_reg.sv
module ccp_cfg_reg
    import ccp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  cfg_t       wr_cfg,
    input  logic [1:0] lock_lvl,
    output cfg_t       cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.dma_upd <= wr_cfg.dma_upd;
            if (!is_locked(lock_lvl)) begin
                cfg.preload  <= wr_cfg.preload;
                cfg.src_trig <= wr_cfg.src_trig;
            end
        end
    end
endmodule

// File: rtl/ccp_com_detect.sv
module ccp_com_detect (
    input  logic clk,
    input  logic rst,
    input  logic sw_com,
    input  logic trig_in,
    input  logic src_trig,
    output logic com_evt
);
    logic trig_q;

    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b0;
        else     trig_q <= trig_in;
    end

    always_comb com_evt = sw_com | (src_trig & trig_in & ~trig_q);
endmodule

// File: rtl/ccp_chan_slot.sv
module ccp_chan_slot
    import ccp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  chan_ctl_t wr_ctl,
    input  logic      preload,
    input  logic      com_evt,
    output chan_ctl_t shadow,
    output chan_ctl_t active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr_en) shadow <= wr_ctl;
            if (!preload) begin
                if (wr_en) active <= wr_ctl;
            end else if (com_evt) begin
                active <= shadow;
            end
        end
    end
endmodule

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
    import ccp_pkg::*;
#(
    parameter int NCH = 4,
    localparam int WORD_W = NCH * SLOT_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [1:0]            lock_lvl,
    input  logic                  sw_com,
    input  logic                  trig_in,
    output logic [NCH-1:0]        ch_en,
    output logic [NCH-1:0]        ch_nen,
    output logic [MODE_W*NCH-1:0] ch_mode,
    output logic                  preload_on,
    output logic                  src_trig,
    output logic                  dma_on_update
);
    cfg_t             cfg;
    logic             com_evt;
    logic             wr_cfg_en;
    logic             wr_ch_en;
    logic [WORD_W-1:0] shadow_w;

    always_comb begin
        wr_cfg_en = wr_en & ~wr_sel;
        wr_ch_en  = wr_en &  wr_sel;
    end

    ccp_cfg_reg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_cfg_en),
        .wr_cfg   (cfg_t'(wr_data[CFG_W-1:0])),
        .lock_lvl (lock_lvl),
        .cfg      (cfg)
    );

    ccp_com_detect u_com (
        .clk      (clk),
        .rst      (rst),
        .sw_com   (sw_com),
        .trig_in  (trig_in),
        .src_trig (cfg.src_trig),
        .com_evt  (com_evt)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_ctl_t sh;
        chan_ctl_t act;

        ccp_chan_slot u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_ch_en),
            .wr_ctl  (chan_ctl_t'(wr_data[c*SLOT_W +: SLOT_W])),
            .preload (cfg.preload),
            .com_evt (com_evt),
            .shadow  (sh),
            .active  (act)
        );

        always_comb begin
            shadow_w[c*SLOT_W +: SLOT_W] = sh;
            ch_en[c]                     = act.en;
            ch_nen[c]                    = act.nen;
            ch_mode[c*MODE_W +: MODE_W]  = act.mode;
        end
    end

    always_comb begin
        preload_on    = cfg.preload;
        src_trig      = cfg.src_trig;
        dma_on_update = cfg.dma_upd;
    end
endmodule

// File: rtl/ccp_ctrl_chk.sv
module ccp_ctrl_chk #(
    parameter int NCH = 4,
    localparam int WORD_W = NCH * 5
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [WORD_W-1:0] wr_data,
    input logic [1:0]        lock_lvl,
    input logic              sw_com,
    input logic              trig_in,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    ch_nen,
    input logic [3*NCH-1:0]  ch_mode,
    input logic              preload_on,
    input logic              src_trig,
    input logic              dma_on_update,
    input logic [WORD_W-1:0] shadow_w
);
    logic [WORD_W-1:0] act_w;
    logic              prev_trig;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            act_w[c*5]        = ch_en[c];
            act_w[c*5+1]      = ch_nen[c];
            act_w[c*5+2 +: 3] = ch_mode[c*3 +: 3];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev_trig <= 1'b0;
        else     prev_trig <= trig_in;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (act_w == '0 && !preload_on && !src_trig && !dma_on_update));

    // R2
    a_r2_direct_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel && !preload_on) |=> act_w == $past(wr_data));

    // R3
    a_r3_commit_copies: assert property (@(posedge clk) disable iff (rst)
        (preload_on && sw_com) |=> act_w == $past(shadow_w));

    // R3
    a_r3_hold_no_event: assert property (@(posedge clk) disable iff (rst)
        (preload_on && !sw_com && !(src_trig && trig_in && !prev_trig)) |=> $stable(act_w));

    // R5
    a_r5_level_once: assert property (@(posedge clk) disable iff (rst)
        (preload_on && !sw_com && trig_in && prev_trig) |=> $stable(act_w));

    // R7
    a_r7_lock_freeze: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel && lock_lvl != 2'd0) |=> ($stable(preload_on) && $stable(src_trig)));

    // R8
    a_r8_dma_sel: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> dma_on_update == $past(wr_data[2]));
endmodule

bind ccp_ctrl ccp_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_data       (wr_data),
    .lock_lvl      (lock_lvl),
    .sw_com        (sw_com),
    .trig_in       (trig_in),
    .ch_en         (ch_en),
    .ch_nen        (ch_nen),
    .ch_mode       (ch_mode),
    .preload_on    (preload_on),
    .src_trig      (src_trig),
    .dma_on_update (dma_on_update),
    .shadow_w      (shadow_w)
);

// File: tb/sim_ccp_ctrl.sv
module sim_ccp_ctrl;
    localparam int NCH = 4;
    localparam int W   = NCH * 5;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic           wr_sel = 1'b0;
    logic [W-1:0]   wr_data = '0;
    logic [1:0]     lock_lvl = 2'd0;
    logic           sw_com = 1'b0;
    logic           trig_in = 1'b0;
    logic [NCH-1:0] ch_en;
    logic [NCH-1:0] ch_nen;
    logic [3*NCH-1:0] ch_mode;
    logic           preload_on;
    logic           src_trig;
    logic           dma_on_update;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected state
    logic [W-1:0] m_act = '0;
    logic [W-1:0] m_sh  = '0;
    logic         m_pre = 1'b0;
    logic         m_src = 1'b0;
    logic         m_dma = 1'b0;
    logic         m_tq  = 1'b0;

    always #4 clk = ~clk;

    ccp_ctrl #(.NCH(NCH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lock_lvl(lock_lvl), .sw_com(sw_com), .trig_in(trig_in),
        .ch_en(ch_en), .ch_nen(ch_nen), .ch_mode(ch_mode),
        .preload_on(preload_on), .src_trig(src_trig), .dma_on_update(dma_on_update)
    );

    function automatic logic [W-1:0] seen_word();
        logic [W-1:0] v;
        for (int c = 0; c < NCH; c++) begin
            v[c*5]        = ch_en[c];
            v[c*5+1]      = ch_nen[c];
            v[c*5+2 +: 3] = ch_mode[c*3 +: 3];
        end
        return v;
    endfunction

    function automatic logic [W-1:0] pattern(input int k);
        return W'((k * 32'h0009_E3B7) ^ (k << 7) ^ 32'h0005_A5A5);
    endfunction

    // one clock with the given inputs; expected values derived from the requirements
    task automatic step(input string tag, input logic r, input logic we, input logic sel,
                        input logic [W-1:0] d, input logic [1:0] lk,
                        input logic sw, input logic tr);
        logic com;
        logic [W-1:0] got;
        rst = r; wr_en = we; wr_sel = sel; wr_data = d; lock_lvl = lk;
        sw_com = sw; trig_in = tr;
        @(posedge clk);
        if (r) begin
            m_act = '0; m_sh = '0; m_pre = 0; m_src = 0; m_dma = 0; m_tq = 0;
        end else begin
            com = sw | (m_src & tr & ~m_tq);
            if (we && sel && !m_pre)    m_act = d;
            else if (m_pre && com)      m_act = m_sh;
            if (we && sel)              m_sh = d;
            if (we && !sel) begin
                if (lk == 2'd0) begin m_pre = d[0]; m_src = d[1]; end
                m_dma = d[2];
            end
            m_tq = tr;
        end
        @(negedge clk);
        rst = 0; wr_en = 0; sw_com = 0;
        got = seen_word();
        checks++;
        if (got !== m_act || preload_on !== m_pre || src_trig !== m_src || dma_on_update !== m_dma) begin
            errors++;
            $display("FAIL %s: act=%h pre=%b src=%b dma=%b expected act=%h pre=%b src=%b dma=%b",
                     tag, got, preload_on, src_trig, dma_on_update, m_act, m_pre, m_src, m_dma);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        step("R1 reset state", 1, 0, 0, '0, 0, 0, 0);

        // R7 / R8: all config words under every lock level
        for (int lk = 0; lk < 4; lk++) begin
            for (int cw = 0; cw < 8; cw++) begin
                step(lk == 0 ? "R8 config write" : "R7 locked config write",
                     0, 1, 0, W'(cw), 2'(lk), 0, 0);
            end
        end
        step("R7 unlock clear", 0, 1, 0, W'(0), 0, 0, 0);

        // R2: direct writes, commit has no effect (R3)
        for (int k = 0; k < 8; k++) step("R2 direct write", 0, 1, 1, pattern(k), 0, 0, 0);
        step("R3 commit with preload off", 0, 0, 0, '0, 0, 1, 0);
        step("R2 write field layout", 0, 1, 1, W'(20'h8421F), 0, 0, 0);

        // R3 / R4: preload on, software source only
        step("R3 enable preload", 0, 1, 0, W'(1), 0, 0, 0);
        for (int k = 8; k < 12; k++) step("R3 shadowed write holds", 0, 1, 1, pattern(k), 0, 0, 0);
        step("R4 trig ignored rise", 0, 0, 0, '0, 0, 0, 1);
        step("R4 trig ignored high", 0, 0, 0, '0, 0, 0, 1);
        step("R3 software commit", 0, 0, 0, '0, 0, 1, 1);
        step("R4 trig low", 0, 0, 0, '0, 0, 0, 0);

        // R5: trigger source, set while trigger already high
        step("R5 trig high before select", 0, 0, 0, '0, 0, 0, 1);
        step("R5 select trig source", 0, 1, 0, W'(3), 0, 0, 1);
        step("R5 write pending", 0, 1, 1, pattern(20), 0, 0, 1);
        step("R5 already-high level no commit", 0, 0, 0, '0, 0, 0, 1);
        step("R5 trig low", 0, 0, 0, '0, 0, 0, 0);
        step("R5 rising edge commits", 0, 0, 0, '0, 0, 0, 1);
        step("R5 write pending again", 0, 1, 1, pattern(21), 0, 0, 1);
        step("R5 held high no commit", 0, 0, 0, '0, 0, 0, 1);
        step("R5 sw commit while high", 0, 0, 0, '0, 0, 1, 1);
        step("R5 trig low 2", 0, 0, 0, '0, 0, 0, 0);

        // R6: write and commit in the same cycle
        step("R6 stage value", 0, 1, 1, pattern(30), 0, 0, 0);
        step("R6 write with sw commit", 0, 1, 1, pattern(31), 0, 1, 0);
        step("R6 pending value commits next", 0, 0, 0, '0, 0, 1, 0);
        step("R6 write with trig edge", 0, 1, 1, pattern(32), 0, 0, 1);
        step("R6 pending after trig", 0, 0, 0, '0, 0, 0, 0);

        // R7: lock holds preload mode while dma still writes
        step("R7 locked try disable preload", 0, 1, 0, W'(4), 2'd2, 0, 0);
        step("R7 still shadowed under lock", 0, 1, 1, pattern(40), 2'd2, 0, 0);
        step("R7 commit under lock", 0, 0, 0, '0, 2'd2, 1, 0);

        // R1: reset mid-run
        step("R1 stage before reset", 0, 1, 1, pattern(50), 0, 0, 1);
        step("R1 reset clears", 1, 0, 0, '0, 0, 0, 1);
        step("R1 edge detector cleared", 0, 1, 0, W'(3), 0, 0, 1);
        step("R1 shadow cleared commit", 0, 0, 0, '0, 0, 1, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule